// File: doc/BRIEF.md
# Calibrated Wake-Up Controller

This block keeps a low-power system asleep until something worth waking for happens. A wake-up timer counts milliseconds derived from a slow, inaccurate oscillator. To keep that millisecond accurate, the block measures the slow oscillator against a precise reference oscillator. It does this once right after reset and again after every fixed number of milliseconds. While a measurement runs, the block keeps the reference oscillator running, whatever the host has asked for.

Five wake sources feed a sticky status register, and a single active-low interrupt goes low while any status bit is set:

- a falling edge on the external interrupt pin,
- expiry of the timer,
- the low-supply flag,
- the receive-buffer-full flag,
- a host request strobe.

The host reads the register, which clears it.

The block also produces the host's clock through a power-of-two divider. When the host turns the oscillator off, that clock keeps running for a fixed number of pulses before it stops, so the host has time to enter its sleep state.

Top module: `wake_ctl_top`

## Requirements
- R1: The timer fires every `per_m * 2^per_r` milliseconds and sets status bit 1. When `per_m` is 0 the timer is stopped and bit 1 never sets from it.
- R2: After reset `cal_req` is high. A measurement starts at the next `slow_tick` and counts `ref_tick` cycles over the following CAL_SLOW slow ticks, then stores that count. From then on, one millisecond lasts REF_PER_MS reference cycles.
- R3: A new measurement starts after every RECAL_MS milliseconds. Until it completes, the previously stored count stays in use, even if the slow oscillator has changed.
- R4: `ref_osc_on` is high while a measurement runs, while `osc_en` is high, and while the clock tail is running. Otherwise it is low.
- R5: The status bits are assigned as follows: bit 0 is the external pin, bit 2 is low supply, bit 3 is buffer full, and bit 4 is the host request. Bit 0 sets on a 1-to-0 transition of `ext_int_n`; holding the pin low does not set it again.
- R6: `irq_n` is low exactly while any status bit is set. Bits stay set until a cycle with `stat_rd` high clears them. An event in that same cycle leaves its bit set.
- R7: `mclk` has a half period of 2^`div_sel` cycles for `div_sel` 0 to 4. Values above 4 give 16.
- R8: A new `div_sel` value takes effect only when `mclk` falls. The high phase in progress keeps its old length.
- R9: After `osc_en` falls, `mclk` delivers exactly TAIL rising edges and then stays low. If `osc_en` rises again, the tail is cancelled and the clock runs on.
- R10: During reset, `irq_n` is 1, `status` is 0, `mclk` is 0 and `cal_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One strobe per reference oscillator cycle |
| slow_tick | input | 1 | One strobe per slow oscillator cycle |
| osc_en | input | 1 | Host oscillator enable |
| per_m | input | 8 | Timer mantissa, 0 stops the timer |
| per_r | input | 5 | Timer exponent |
| ext_int_n | input | 1 | External interrupt pin, falling edge wakes |
| lowbat | input | 1 | Low-supply flag |
| fifo_full | input | 1 | Receive buffer full flag |
| host_req | input | 1 | Host wake request strobe |
| stat_rd | input | 1 | Status read strobe, clears status |
| div_sel | input | 3 | Host clock divider select |
| irq_n | output | 1 | Interrupt, active low |
| status | output | 5 | Sticky wake-source bits |
| cal_req | output | 1 | Measurement in progress |
| ref_osc_on | output | 1 | Reference oscillator enable request |
| mclk | output | 1 | Divided host clock |

## Verification
The hardest case to reach is the stretch between a change in slow-oscillator speed and the next measurement, when the timer runs on a stale count. The bench waits for `cal_req` to fall, then halves the slow tick period at once. It measures two timer intervals, which must come out at half their nominal length. It then waits through the next measurement and checks that the intervals return to nominal. The clock tail is counted edge by edge after `osc_en` drops, and a second drop follows a re-enable to show the cancelled tail restarts in full.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int SRC_N = 5;
    localparam int TGT_W = 8 + 31;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_ARM  = 2'd1,
        CAL_CNT  = 2'd2
    } cal_st_e;

    // bit order: host[4] fifo[3] lbat[2] tmr[1] ext[0]
    typedef struct packed {
        logic host;
        logic fifo;
        logic lbat;
        logic tmr;
        logic ext;
    } wake_src_t;

    function automatic logic [4:0] half_len(input logic [2:0] sel);
        case (sel)
            3'd0:    half_len = 5'd1;
            3'd1:    half_len = 5'd2;
            3'd2:    half_len = 5'd4;
            3'd3:    half_len = 5'd8;
            default: half_len = 5'd16;
        endcase
    endfunction

    function automatic logic [TGT_W-1:0] timer_target(input logic [7:0] m, input logic [4:0] r);
        timer_target = TGT_W'(m) << r;
    endfunction

endpackage

// File: rtl/wk_cal_unit.sv
module wk_cal_unit
    import wk_pkg::*;
#(
    parameter int CAL_SLOW    = 1024,
    parameter int CAL_DEFAULT = 320000,
    parameter int RATIO_W     = 24,
    parameter int RECAL_MS    = 30000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_tick,
    input  logic               slow_tick,
    input  logic               ms_tick,
    output logic               cal_busy,
    output logic [RATIO_W-1:0] ratio
);
    localparam int SL_W = $clog2(CAL_SLOW + 1);
    localparam int RC_W = $clog2(RECAL_MS + 1);

    cal_st_e            st;
    logic [RATIO_W-1:0] refcnt;
    logic [SL_W-1:0]    slowcnt;
    logic [RC_W-1:0]    rc;
    logic [RATIO_W-1:0] ref_inc;

    assign ref_inc  = {{(RATIO_W-1){1'b0}}, ref_tick};
    assign cal_busy = (st != CAL_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CAL_ARM;
            ratio   <= RATIO_W'(CAL_DEFAULT);
            refcnt  <= '0;
            slowcnt <= '0;
            rc      <= '0;
        end else begin
            case (st)
                CAL_IDLE: begin
                    if (ms_tick) begin
                        if (rc == RC_W'(RECAL_MS - 1)) begin
                            st <= CAL_ARM;
                            rc <= '0;
                        end else begin
                            rc <= rc + 1'b1;
                        end
                    end
                end
                CAL_ARM: begin
                    if (slow_tick) begin
                        st      <= CAL_CNT;
                        refcnt  <= '0;
                        slowcnt <= '0;
                    end
                end
                CAL_CNT: begin
                    refcnt <= refcnt + ref_inc;
                    if (slow_tick) begin
                        if (slowcnt == SL_W'(CAL_SLOW - 1)) begin
                            ratio <= refcnt + ref_inc;
                            st    <= CAL_IDLE;
                            rc    <= '0;
                        end else begin
                            slowcnt <= slowcnt + 1'b1;
                        end
                    end
                end
                default: st <= CAL_IDLE;
            endcase
        end
    end

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st != CAL_CNT) |=> $stable(ratio)); // R3

    AST_ARM_WAITS: assert property (@(posedge clk) disable iff (rst)
        (st == CAL_ARM && !slow_tick) |=> (st == CAL_ARM)); // R2

endmodule

// File: rtl/wk_period_timer.sv
module wk_period_timer
    import wk_pkg::*;
#(
    parameter int CAL_SLOW   = 1024,
    parameter int REF_PER_MS = 10000,
    parameter int RATIO_W    = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slow_tick,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [7:0]         per_m,
    input  logic [4:0]         per_r,
    output logic               ms_tick,
    output logic               expire
);
    localparam int ACC_W = RATIO_W + 2;
    localparam longint THR = longint'(REF_PER_MS) * longint'(CAL_SLOW);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_n;
    logic [TGT_W-1:0] cnt;
    logic [TGT_W-1:0] tgt;

    assign acc_n = acc + ACC_W'(ratio);
    assign tgt   = timer_target(per_m, per_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            ms_tick <= 1'b0;
        end else if (slow_tick) begin
            if (acc_n >= ACC_W'(THR)) begin
                acc     <= acc_n - ACC_W'(THR);
                ms_tick <= 1'b1;
            end else begin
                acc     <= acc_n;
                ms_tick <= 1'b0;
            end
        end else begin
            ms_tick <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (per_m == 8'd0) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else if (ms_tick) begin
            if (cnt + 1'b1 >= tgt) begin
                cnt    <= '0;
                expire <= 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
                expire <= 1'b0;
            end
        end else begin
            expire <= 1'b0;
        end
    end

    AST_TMR_OFF: assert property (@(posedge clk) disable iff (rst)
        (per_m == 8'd0) |=> !expire); // R1

    AST_EXP_NEEDS_MS: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> !expire); // R1

endmodule

// File: rtl/wk_irq_agg.sv
module wk_irq_agg
    import wk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_int_n,
    input  logic             tmr_evt,
    input  logic             lowbat,
    input  logic             fifo_full,
    input  logic             host_req,
    input  logic             rd,
    output logic [SRC_N-1:0] status,
    output logic             irq_n
);
    logic      ext_prev;
    wake_src_t evt;
    wake_src_t sticky;

    always_comb begin
        evt.ext  = ext_prev & ~ext_int_n;
        evt.tmr  = tmr_evt;
        evt.lbat = lowbat;
        evt.fifo = fifo_full;
        evt.host = host_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= 1'b1;
            sticky   <= '0;
        end else begin
            ext_prev <= ext_int_n;
            if (rd) sticky <= evt;
            else    sticky <= sticky | evt;
        end
    end

    assign status = sticky;
    assign irq_n  = ~(|sticky);

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd && evt == '0) |=> irq_n); // R6

    AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!rd && !irq_n) |=> !irq_n); // R6

    AST_EXT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (rd && !ext_prev) |=> !status[0]); // R5

endmodule

// File: rtl/wk_clk_out.sv
module wk_clk_out
    import wk_pkg::*;
#(
    parameter int TAIL = 196
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_en,
    input  logic [2:0] div_sel,
    output logic       mclk,
    output logic       busy
);
    localparam int TW = $clog2(TAIL + 1);

    logic [2:0]    act_sel;
    logic [4:0]    dcnt;
    logic [4:0]    half;
    logic          osc_d;
    logic [TW-1:0] tail;
    logic          run;
    logic          at_end;
    logic          rise;

    assign half   = half_len(act_sel);
    assign run    = osc_en | osc_d | (tail != '0) | mclk;
    assign at_end = (dcnt == half - 5'd1);
    assign rise   = run & at_end & ~mclk;
    assign busy   = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            mclk    <= 1'b0;
            dcnt    <= '0;
            act_sel <= '0;
            osc_d   <= 1'b0;
        end else begin
            osc_d <= osc_en;
            if (run) begin
                if (at_end) begin
                    dcnt <= '0;
                    mclk <= ~mclk;
                    if (mclk) act_sel <= div_sel;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end else begin
                dcnt    <= '0;
                mclk    <= 1'b0;
                act_sel <= div_sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= '0;
        end else if (osc_en) begin
            tail <= '0;
        end else if (osc_d) begin
            tail <= TW'(TAIL) - TW'(rise);
        end else if (rise && tail != '0) begin
            tail <= tail - 1'b1;
        end
    end

    AST_DIV_LOWPH: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_sel) |-> !mclk); // R8

    AST_MCLK_STOP: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !osc_d && tail == '0 && !mclk) |=> !mclk); // R9

    AST_TAIL_MAX: assert property (@(posedge clk) disable iff (rst)
        tail <= TW'(TAIL)); // R9

endmodule

// File: rtl/wake_ctl_top.sv
module wake_ctl_top
    import wk_pkg::*;
#(
    parameter int CAL_SLOW    = 1024,
    parameter int REF_PER_MS  = 10000,
    parameter int CAL_DEFAULT = 320000,
    parameter int RATIO_W     = 24,
    parameter int RECAL_MS    = 30000,
    parameter int TAIL        = 196
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             slow_tick,
    input  logic             osc_en,
    input  logic [7:0]       per_m,
    input  logic [4:0]       per_r,
    input  logic             ext_int_n,
    input  logic             lowbat,
    input  logic             fifo_full,
    input  logic             host_req,
    input  logic             stat_rd,
    input  logic [2:0]       div_sel,
    output logic             irq_n,
    output logic [SRC_N-1:0] status,
    output logic             cal_req,
    output logic             ref_osc_on,
    output logic             mclk
);
    logic [RATIO_W-1:0] ratio;
    logic               ms_tick;
    logic               tmr_exp;
    logic               clk_busy;

    wk_cal_unit #(
        .CAL_SLOW(CAL_SLOW), .CAL_DEFAULT(CAL_DEFAULT),
        .RATIO_W(RATIO_W), .RECAL_MS(RECAL_MS)
    ) u_cal (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .slow_tick(slow_tick),
        .ms_tick(ms_tick), .cal_busy(cal_req), .ratio(ratio)
    );

    wk_period_timer #(
        .CAL_SLOW(CAL_SLOW), .REF_PER_MS(REF_PER_MS), .RATIO_W(RATIO_W)
    ) u_tmr (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .ratio(ratio),
        .per_m(per_m), .per_r(per_r), .ms_tick(ms_tick), .expire(tmr_exp)
    );

    wk_irq_agg u_irq (
        .clk(clk), .rst(rst), .ext_int_n(ext_int_n), .tmr_evt(tmr_exp),
        .lowbat(lowbat), .fifo_full(fifo_full), .host_req(host_req),
        .rd(stat_rd), .status(status), .irq_n(irq_n)
    );

    wk_clk_out #(.TAIL(TAIL)) u_clk (
        .clk(clk), .rst(rst), .osc_en(osc_en), .div_sel(div_sel),
        .mclk(mclk), .busy(clk_busy)
    );

    assign ref_osc_on = osc_en | cal_req | clk_busy;

    AST_OSC_CAL: assert property (@(posedge clk) disable iff (rst)
        cal_req |-> ref_osc_on); // R4

    AST_TMR_IRQ: assert property (@(posedge clk) disable iff (rst)
        tmr_exp |=> (status[1] && !irq_n)); // R1

endmodule

// File: tb/sim_wake_ctl_top.sv
module sim_wake_ctl_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b1;
    logic       slow_tick = 1'b0;
    logic       osc_en = 1'b0;
    logic [7:0] per_m = 8'd0;
    logic [4:0] per_r = 5'd0;
    logic       ext_int_n = 1'b1;
    logic       lowbat = 1'b0;
    logic       fifo_full = 1'b0;
    logic       host_req = 1'b0;
    logic       stat_rd = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       irq_n;
    logic [4:0] status;
    logic       cal_req;
    logic       ref_osc_on;
    logic       mclk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int slow_per = 4;
    int sc = 0;

    wake_ctl_top #(
        .CAL_SLOW(4), .REF_PER_MS(8), .CAL_DEFAULT(4),
        .RATIO_W(16), .RECAL_MS(40), .TAIL(196)
    ) u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .slow_tick(slow_tick),
        .osc_en(osc_en), .per_m(per_m), .per_r(per_r), .ext_int_n(ext_int_n),
        .lowbat(lowbat), .fifo_full(fifo_full), .host_req(host_req),
        .stat_rd(stat_rd), .div_sel(div_sel), .irq_n(irq_n), .status(status),
        .cal_req(cal_req), .ref_osc_on(ref_osc_on), .mclk(mclk)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        sc = (sc + 1 >= slow_per) ? 0 : sc + 1;
        slow_tick = (sc == 0);
    end

    // fire mask {host,fifo,lbat,tmr,ext}, expected status
    localparam logic [9:0] VEC [6] = '{
        {5'b00001, 5'b00001},
        {5'b00100, 5'b00100},
        {5'b01000, 5'b01000},
        {5'b10000, 5'b10000},
        {5'b01101, 5'b01101},
        {5'b11101, 5'b11101}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cal_done();
        int k = 0;
        while (!cal_req && k < 3000) begin @(negedge clk); k++; end
        while (cal_req && k < 3000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_tmr(output int t);
        int k = 0;
        @(negedge clk);
        while (irq_n && k < 2000) begin @(negedge clk); k++; end
        t = cyc;
        chk(status == 5'b00010, "R1 timer status", int'(status), 2);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic measure_high(output int n);
        int k = 0;
        while (mclk && k < 100) begin @(negedge clk); k++; end
        while (!mclk && k < 200) begin @(negedge clk); k++; end
        n = 0;
        while (mclk && k < 300) begin n++; @(negedge clk); k++; end
    endtask

    task automatic count_tail(output int n);
        bit prev;
        prev = mclk;
        osc_en = 1'b0;
        n = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (mclk && !prev) n++;
            prev = mclk;
        end
    endtask

    initial begin
        int t0, t1, t2, n;
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk(irq_n == 1'b1, "R10 irq_n", int'(irq_n), 1);
        chk(status == 5'd0, "R10 status", int'(status), 0);
        chk(mclk == 1'b0, "R10 mclk", int'(mclk), 0);
        chk(cal_req == 1'b1, "R10 cal_req", int'(cal_req), 1);
        rst = 1'b0;
        // R2 startup calibration request and completion
        @(negedge clk);
        chk(cal_req == 1'b1, "R2 cal_req after reset", int'(cal_req), 1);
        chk(ref_osc_on == 1'b1, "R4 osc on during cal", int'(ref_osc_on), 1);
        wait_cal_done();
        chk(cal_req == 1'b0, "R2 cal done", int'(cal_req), 0);

        // R1 / R2 timer intervals with calibrated ms (8 cycles)
        per_m = 8'd3; per_r = 5'd1;
        wait_tmr(t0); wait_tmr(t1); wait_tmr(t2);
        chk(t2 - t1 == 48, "R1 R2 period 3*2^1 ms", t2 - t1, 48);
        per_m = 8'd1; per_r = 5'd2;
        wait_tmr(t0); wait_tmr(t1); wait_tmr(t2);
        chk(t2 - t1 == 32, "R1 period 1*2^2 ms", t2 - t1, 32);

        // R3 stale count until recalibration
        per_m = 8'd3; per_r = 5'd1;
        wait_cal_done();
        slow_per = 2;
        wait_tmr(t0); wait_tmr(t1); wait_tmr(t2);
        chk(t2 - t1 == 24, "R3 stale ratio interval", t2 - t1, 24);
        wait_cal_done();
        wait_tmr(t0); wait_tmr(t1); wait_tmr(t2);
        chk(t2 - t1 == 48, "R3 recalibrated interval", t2 - t1, 48);

        // R1 timer off
        per_m = 8'd0;
        repeat (5) @(negedge clk);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        repeat (300) @(negedge clk);
        chk(status == 5'd0, "R1 m=0 no expiry", int'(status), 0);

        // R5 R6 source table
        foreach (VEC[i]) begin
            ext_int_n = ~VEC[i][5];
            lowbat    = VEC[i][7];
            fifo_full = VEC[i][8];
            host_req  = VEC[i][9];
            @(negedge clk);
            ext_int_n = 1'b1; lowbat = 1'b0; fifo_full = 1'b0; host_req = 1'b0;
            chk(status == VEC[i][4:0], "R5 source bits", int'(status), int'(VEC[i][4:0]));
            chk(irq_n == 1'b0, "R6 irq low", int'(irq_n), 0);
            stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
            chk(status == 5'd0 && irq_n, "R6 read clears", int'(status), 0);
        end

        // R5 held-low pin does not retrigger
        ext_int_n = 1'b0;
        @(negedge clk);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        repeat (4) @(negedge clk);
        chk(status == 5'd0, "R5 level not an edge", int'(status), 0);
        ext_int_n = 1'b1;
        @(negedge clk);

        // R6 event in the read cycle survives
        host_req = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        host_req = 1'b0; stat_rd = 1'b0;
        chk(status == 5'b10000 && !irq_n, "R6 same-cycle event", int'(status), 16);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;

        // R7 divider ratios
        osc_en = 1'b1;
        for (int s = 0; s < 6; s++) begin
            int sel, expv;
            sel = (s == 5) ? 7 : s;
            expv = (s == 5) ? 16 : (1 << s);
            div_sel = 3'(sel);
            repeat (40) @(negedge clk);
            measure_high(n);
            chk(n == expv, "R7 half period", n, expv);
        end

        // R8 change only at low phase
        div_sel = 3'd4;
        repeat (40) @(negedge clk);
        while (mclk) @(negedge clk);
        while (!mclk) @(negedge clk);
        n = 1;
        repeat (2) begin @(negedge clk); n++; end
        div_sel = 3'd0;
        @(negedge clk);
        while (mclk) begin n++; @(negedge clk); end
        chk(n == 16, "R8 high phase kept", n, 16);
        n = 0;
        while (!mclk) begin n++; @(negedge clk); end
        chk(n == 1, "R8 new low phase", n, 1);

        // R9 tail count, R4 oscillator request
        repeat (5) @(negedge clk);
        count_tail(n);
        chk(n == 196, "R9 tail pulses", n, 196);
        chk(mclk == 1'b0, "R9 clock stopped", int'(mclk), 0);
        chk(ref_osc_on == cal_req, "R4 osc follows cal only", int'(ref_osc_on), int'(cal_req));
        osc_en = 1'b1;
        repeat (20) @(negedge clk);
        osc_en = 1'b0;
        repeat (20) @(negedge clk);
        osc_en = 1'b1;
        repeat (20) @(negedge clk);
        count_tail(n);
        chk(n == 196, "R9 tail after cancel", n, 196);

        // R4 calibration alone holds oscillator on
        while (!cal_req) @(negedge clk);
        chk(ref_osc_on == 1'b1, "R4 osc on for cal", int'(ref_osc_on), 1);
        while (cal_req) @(negedge clk);
        chk(ref_osc_on == 1'b0, "R4 osc off after cal", int'(ref_osc_on), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule